// File: doc/BRIEF.md
# Gapless Streaming SPI Master

This block is an SPI master that runs entirely in one fast system clock domain. It produces a slower serial clock by counting a programmable number of system cycles per half period. The serial clock is a plain register output. Bytes written into a small transmit queue are shifted out MSB first. Bytes gathered from the serial input are placed into a receive queue for the host to read.

When another byte is waiting at the moment a byte finishes, the next byte starts at once. The serial clock then keeps its exact period across the byte boundary, with no idle clocks. When nothing is waiting, the clock parks low. Chip select is released half a serial period after the last falling edge. The host can write the next byte while the current one is still shifting, so there is no dead zone between writes.

Chip select always leads the first rising clock edge by half a serial period. The serial output changes only when chip select falls or when the serial clock falls, which is the usual mode-0 timing.

Top module: `spi_stream_master`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), cs_n is 1 and sclk, mosi and busy are 0. tx_full is 0 and rx_empty is 1.
- R2: Each sclk half period lasts exactly div_half system cycles. A div_half of 0 is treated as 1. sclk is 0 whenever cs_n is 1.
- R3: cs_n falls exactly div_half cycles before the first sclk rising edge of a transfer. The two never change in the same cycle.
- R4: Bytes are sent MSB first. The first bit appears on mosi in the cycle cs_n falls. Later bits change only in the cycle sclk falls, so mosi holds steady while sclk is 1.
- R5: miso is sampled in the cycle sclk rises. The sampled bits are assembled MSB first, and the byte is written into the receive queue at its eighth rising edge.
- R6: If the transmit queue holds a byte when the eighth falling edge of a byte occurs, that byte is fetched in the same cycle. Its MSB goes out on mosi in that cycle, and successive rising edges stay exactly 2*div_half cycles apart.
- R7: If the transmit queue is empty at the eighth falling edge, sclk stays 0. cs_n returns to 1 exactly div_half cycles after that falling edge.
- R8: busy is 1 from the cycle cs_n falls until the cycle cs_n rises.
- R9: tx_full is 1 when TX_DEPTH bytes are waiting. A tx_push while tx_full is 1 is ignored, and that byte is never sent.
- R10: rx_data shows the oldest unread received byte, and rx_pop removes it. rx_empty is 1 when no received byte remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_half | input | DIV_W | System cycles per sclk half period (0 acts as 1); hold constant during a transfer |
| tx_data | input | DATA_W | Byte to queue for sending |
| tx_push | input | 1 | Write tx_data into the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| rx_data | output | DATA_W | Oldest received byte |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transfer in progress |

## Verification
On every cycle, the assertions check these rules:
- sclk stays low while chip select is idle.
- Chip select never falls on a cycle where sclk rises.
- mosi does not move while sclk is high.
- A received byte is written only on a rising serial edge.
- The half-period counter stays in range, and neither queue exceeds its depth.

The bench scenarios check the behaviour that needs cycle counting and data knowledge:
- Exact edge spacing across byte boundaries at several divider settings, including a byte added mid-transfer.
- The lead and trail margins of chip select.
- MSB-first content in both directions, checked against a slave model.
- The byte that is dropped when the transmit queue is full.

// File: rtl/spi_stream_pkg.sv
// Shared types for the streaming SPI master.
package spi_stream_pkg;
    // Sequencer phases: idle, chip-select lead, bit shifting, chip-select trail.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spi_phase_e;
endpackage

// File: rtl/spi_word_fifo.sv
// Show-ahead synchronous FIFO.
// rd_data always shows the oldest entry. A push while full and a pop while
// empty are both ignored. A push and a pop may occur in the same cycle.
// Assumes DEPTH >= 2.
module spi_word_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wr_data,
    input  logic         pop,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH-1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_wr   = push && !full;
    assign do_rd   = pop && !empty;
    assign rd_data = mem[rptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
    a_r9_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/spi_half_period_timer.sv
// Half-period tick generator.
// While run is high, it pulses tick every div_half system cycles (0 acts as
// 1). It restarts from zero whenever run is low. div_half is assumed stable
// while run is high.
module spi_half_period_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div_half == '0) ? DIV_W'(1) : div_half;
    assign tick    = run && (cnt == div_eff - DIV_W'(1));

    // Count system cycles within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div_eff);
endmodule

// File: rtl/spi_shift_engine.sv
// Serial sequencer.
// It drives cs_n, sclk and mosi as registers and samples miso. It fetches
// bytes from a show-ahead transmit queue and emits received bytes. Each
// state change happens on a half-period tick from the timer, with the timer
// running whenever the sequencer is not idle. Uses mode 0: mosi changes on
// the sclk fall, and miso is sampled on the sclk rise.
module spi_shift_engine
    import spi_stream_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         tx_empty,
    input  logic [W-1:0] tx_word,
    output logic         tx_pop,
    input  logic         miso,
    output logic         rx_push,
    output logic [W-1:0] rx_word,
    output logic         run,
    output logic         sclk,
    output logic         mosi,
    output logic         cs_n,
    output logic         busy
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W-1);

    spi_phase_e    phase;
    logic [W-1:0]  tx_sh;
    logic [W-1:0]  rx_sh;
    logic [CW-1:0] bitcnt;
    logic          rise_now, fall_now, last_bit, start_now, chain_now;

    assign run       = (phase != ST_IDLE);
    assign last_bit  = (bitcnt == LAST_BIT);
    assign rise_now  = tick && ((phase == ST_LEAD) || (phase == ST_SHIFT && !sclk));
    assign fall_now  = tick && (phase == ST_SHIFT) && sclk;
    assign start_now = (phase == ST_IDLE) && !tx_empty;
    assign chain_now = fall_now && last_bit && !tx_empty;

    // Fetch a byte at the start of a transfer or at a gapless boundary.
    always_comb begin
        tx_pop  = start_now || chain_now;
        rx_push = rise_now && last_bit;
        rx_word = {rx_sh[W-2:0], miso};
    end

    // Phase, clock, select and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= ST_IDLE;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            cs_n   <= 1'b1;
            busy   <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            bitcnt <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (start_now) begin
                        tx_sh  <= tx_word;
                        mosi   <= tx_word[W-1];
                        bitcnt <= '0;
                        cs_n   <= 1'b0;
                        busy   <= 1'b1;
                        phase  <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[W-2:0], miso};
                        phase <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (rise_now) begin
                        sclk  <= 1'b1;
                        rx_sh <= {rx_sh[W-2:0], miso};
                    end else if (fall_now) begin
                        sclk <= 1'b0;
                        if (!last_bit) begin
                            bitcnt <= bitcnt + 1'b1;
                            tx_sh  <= tx_sh << 1;
                            mosi   <= tx_sh[W-2];
                        end else if (chain_now) begin
                            bitcnt <= '0;
                            tx_sh  <= tx_word;
                            mosi   <= tx_word[W-1];
                        end else begin
                            phase <= ST_TRAIL;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        busy  <= 1'b0;
                        phase <= ST_IDLE;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r3_select_leads_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(!cs_n));
    a_r3_select_not_with_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> !sclk);
    a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));
    a_r5_push_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> $rose(sclk));
    a_r7_trail_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_TRAIL) |-> !sclk);
endmodule

// File: rtl/spi_stream_master.sv
// Top level of the streaming SPI master.
// It ties together the transmit queue, the receive queue, the half-period
// timer and the serial sequencer. Everything runs on clk. sclk is a register
// output, never a gated clock.
module spi_stream_master #(
    parameter int DATA_W   = 8,
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 8,
    parameter int DIV_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_half,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_push,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_pop,
    output logic              rx_empty,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              busy
);
    logic              tx_empty, tx_pop, rx_push, rx_full, run, tick;
    logic [DATA_W-1:0] tx_word, rx_word;

    spi_word_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wr_data(tx_data),
        .pop(tx_pop), .rd_data(tx_word), .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wr_data(rx_word),
        .pop(rx_pop), .rd_data(rx_data), .full(rx_full), .empty(rx_empty)
    );

    spi_half_period_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .div_half(div_half), .tick(tick)
    );

    spi_shift_engine #(.W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_empty(tx_empty),
        .tx_word(tx_word), .tx_pop(tx_pop), .miso(miso), .rx_push(rx_push),
        .rx_word(rx_word), .run(run), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .busy(busy)
    );

    a_r6_fetch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && !cs_n) |=> $fell(sclk));
    a_r10_rx_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> rx_full);
endmodule

// File: tb/tb_spi_stream_master.sv
module tb_spi_stream_master;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_half = 8'd1;
    logic [7:0] tx_data = '0;
    logic       tx_push = 1'b0;
    logic       tx_full;
    logic [7:0] rx_data;
    logic       rx_pop = 1'b0;
    logic       rx_empty;
    logic       sclk, mosi, cs_n, busy;
    logic       miso = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] exp_mosi[$];
    logic [7:0] exp_rx[$];
    logic [7:0] slave_q[$];

    spi_stream_master dut (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .tx_data(tx_data),
        .tx_push(tx_push), .tx_full(tx_full), .rx_data(rx_data), .rx_pop(rx_pop),
        .rx_empty(rx_empty), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int div_eff();
        return (div_half == 8'd0) ? 1 : int'(div_half);
    endfunction

    // Driver: queue one byte, and record the expected serial traffic if it is accepted.
    task automatic push_byte(input logic [7:0] d, input logic [7:0] s, input bit acc);
        @(negedge clk);
        tx_data = d;
        tx_push = 1'b1;
        if (acc) begin
            exp_mosi.push_back(d);
            exp_rx.push_back(s);
            slave_q.push_back(s);
        end
    endtask

    task automatic end_push();
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic wait_done();
        while (exp_mosi.size() != 0) @(negedge clk);
        while (!cs_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Read out the receive queue and compare it in order (R10, R5).
    task automatic drain_rx();
        while (1) begin
            @(negedge clk);
            if (rx_empty) break;
            if (exp_rx.size() == 0) begin
                check(1'b0, "R10", "unexpected rx byte", int'(rx_data), -1);
            end else begin
                logic [7:0] e;
                e = exp_rx.pop_front();
                check(rx_data == e, "R5", "rx byte MSB-first", int'(rx_data), int'(e));
            end
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
        check(exp_rx.size() == 0, "R10", "rx bytes missing", exp_rx.size(), 0);
        check(rx_empty == 1'b1, "R10", "rx_empty after drain", int'(rx_empty), 1);
    endtask

    // Monitor and slave model: timing, mosi content, miso drive.
    int         cyc = 0;
    int         cs_fall_cyc = 0, last_rise = 0, last_fall = 0;
    bit         first_rise = 0;
    logic       prev_sclk = 1'b0, prev_cs = 1'b1;
    logic [7:0] mbits = '0;
    int         mcnt = 0;
    logic [7:0] ssh = '0;
    int         scnt = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                cs_fall_cyc = cyc;
                first_rise  = 1;
                mcnt = 0;
                scnt = 0;
                ssh  = (slave_q.size() != 0) ? slave_q.pop_front() : 8'h00;
                miso = ssh[7];
            end
            if (!prev_sclk && sclk) begin
                if (first_rise) begin
                    check(cyc - cs_fall_cyc == div_eff(), "R3", "cs lead cycles",
                          cyc - cs_fall_cyc, div_eff());
                    check(busy == 1'b1, "R8", "busy during transfer", int'(busy), 1);
                    first_rise = 0;
                end else begin
                    check(cyc - last_rise == 2*div_eff(), "R6", "rise spacing",
                          cyc - last_rise, 2*div_eff());
                end
                last_rise = cyc;
                mbits = {mbits[6:0], mosi};
                mcnt++;
                scnt++;
                if (mcnt == 8) begin
                    if (exp_mosi.size() == 0) begin
                        check(1'b0, "R4", "unexpected mosi byte", int'(mbits), -1);
                    end else begin
                        logic [7:0] e;
                        e = exp_mosi.pop_front();
                        check(mbits == e, "R4", "mosi byte MSB-first", int'(mbits), int'(e));
                    end
                    mcnt = 0;
                end
            end
            if (prev_sclk && !sclk) begin
                check(cyc - last_rise == div_eff(), "R2", "high half period",
                      cyc - last_rise, div_eff());
                last_fall = cyc;
                if (scnt == 8) begin
                    scnt = 0;
                    if (slave_q.size() != 0) begin
                        ssh  = slave_q.pop_front();
                        miso = ssh[7];
                    end
                end else begin
                    ssh  = ssh << 1;
                    miso = ssh[7];
                end
            end
            if (!prev_cs && cs_n) begin
                check(cyc - last_fall == div_eff(), "R7", "cs trail cycles",
                      cyc - last_fall, div_eff());
                check(mcnt == 0, "R7", "partial byte at release", mcnt, 0);
                check(busy == 1'b0, "R8", "busy after release", int'(busy), 0);
            end
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end

    // Watchdog.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run hung actual=%0d expected=finish", WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1, "R1", "cs_n reset", int'(cs_n), 1);
        check(sclk == 1'b0, "R1", "sclk reset", int'(sclk), 0);
        check(mosi == 1'b0, "R1", "mosi reset", int'(mosi), 0);
        check(busy == 1'b0, "R1", "busy reset", int'(busy), 0);
        check(tx_full == 1'b0, "R1", "tx_full reset", int'(tx_full), 0);
        check(rx_empty == 1'b1, "R1", "rx_empty reset", int'(rx_empty), 1);

        // Single byte at the fastest divider (R2, R4, R5, R7)
        div_half = 8'd1;
        push_byte(8'hA5, 8'h3C, 1);
        end_push();
        wait_done();
        drain_rx();

        // Back-to-back burst, gapless (R6)
        div_half = 8'd3;
        push_byte(8'h01, 8'hC3, 1);
        push_byte(8'h80, 8'h5A, 1);
        push_byte(8'hFF, 8'h00, 1);
        end_push();
        wait_done();
        drain_rx();

        // Top-up while shifting: byte added mid-transfer still chains (R6)
        div_half = 8'd2;
        push_byte(8'h6E, 8'h81, 1);
        end_push();
        repeat (5) @(negedge clk);
        push_byte(8'h13, 8'hF0, 1);
        end_push();
        wait_done();
        drain_rx();

        // Divider of zero acts as one (R2)
        div_half = 8'd0;
        push_byte(8'h99, 8'h66, 1);
        push_byte(8'h42, 8'hBD, 1);
        end_push();
        wait_done();
        drain_rx();

        // Full transmit queue: the extra push is dropped (R9)
        div_half = 8'd4;
        for (int i = 0; i < 5; i++) push_byte(8'h10 + 8'(i), 8'hE0 + 8'(i), 1);
        @(negedge clk);
        check(tx_full == 1'b1, "R9", "tx_full with depth waiting", int'(tx_full), 1);
        tx_data = 8'hEE;
        tx_push = 1'b1;
        end_push();
        wait_done();
        drain_rx();
        check(tx_full == 1'b0, "R9", "tx_full after drain", int'(tx_full), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule